// File: doc/BRIEF.md
# Three-lane block-parallel FIR filter

This block computes a three-tap finite impulse response filter over a stream in which three consecutive samples arrive together on each clock. Lane 0 of the input bus carries the oldest sample of the group and lane 2 the newest. The block returns the three matching filter outputs on a three-lane output bus one clock later. The effective sample rate is therefore three times the clock rate, while each lane still has the logic depth of one multiply followed by two additions.

The lanes need the two samples that came just before the current group. These are kept in two history registers. Each register holds a sample from the last accepted group, so one register stands for a delay of three sample periods. Groups offered without the valid flag are ignored. The history then keeps the samples of the last valid group, and the output register keeps its previous result. The three coefficients are fixed at elaboration time. Every sum is kept at full precision: the product width plus two guard bits.

Top module: `par3_fir`

## Requirements
- R1: With `in_valid` high, output lane 0 on the next cycle equals A·s0 + B·p2 + C·p1. Here s0 is input lane 0, and p2 and p1 are input lanes 2 and 1 of the last previously accepted group.
- R2: With `in_valid` high, output lane 1 on the next cycle equals A·s1 + B·s0 + C·p2.
- R3: With `in_valid` high, output lane 2 on the next cycle equals A·s2 + B·s1 + C·s0. This lane uses only the current group.
- R4: `out_valid` equals `in_valid` delayed by exactly one clock.
- R5: After reset, the samples that precede the first accepted group count as zero. This holds both at power-up and after a reset applied in the middle of a stream.
- R6: A cycle with `in_valid` low does not change the history. The next valid group uses the samples of the last valid group, whatever data was on `in_data` in between.
- R7: In the cycle after `in_valid` was low, `out_data` is unchanged from its previous value.
- R8: While reset is asserted, `out_valid` is 0 and `out_data` is all zeros.
- R9: Each lane output is a 34-bit two's-complement sum that does not wrap for any 16-bit samples, including full-scale negative samples combined with full-scale negative coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample group is present on `in_data` |
| in_data | input | 48 | Three signed 16-bit samples; bits 15:0 hold the oldest sample (lane 0) and bits 47:32 the newest (lane 2) |
| out_valid | output | 1 | A result group is present on `out_data` |
| out_data | output | 102 | Three signed 34-bit results; bits 33:0 hold lane 0 and bits 101:68 hold lane 2 |

## Verification
The lane properties compare each output against a product sum. That sum is built from the inputs of the previous cycle and from a shadow copy of the last accepted group, so they assume that `in_valid` and `in_data` change only away from the rising edge. They also assume that `in_valid` is low throughout reset. The latency and hold properties are armed only once reset was already released at the previous edge, so they make no claim about the first edge after release. The stimulus drives every input on the falling clock edge, keeps `in_valid` low whenever reset is asserted, and puts junk data on the bus during idle cycles so that the history rules are actually exercised.

// File: rtl/par3_fir_pkg.sv
package par3_fir_pkg;

    // Sample and coefficient precision
    localparam int SAMPLE_W  = 16;
    localparam int COEF_W    = 16;
    // Filter length and block size
    localparam int NUM_TAPS  = 3;
    localparam int BLK_LANES = 3;
    // Derived widths: full product plus guard bits for the tap sum
    localparam int PROD_W    = SAMPLE_W + COEF_W;
    localparam int GUARD_W   = $clog2(NUM_TAPS);
    localparam int SUM_W     = PROD_W + GUARD_W;
    // Samples kept from the previous block
    localparam int HIST_D    = NUM_TAPS - 1;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [SUM_W-1:0]    sum_t;

endpackage

// File: rtl/par3_fir_hist.sv
// Block-delay store: keeps the newest HIST samples of the last accepted block.
// taps[0] is the sample just before the current block, taps[1] the one before it.
module par3_fir_hist
    import par3_fir_pkg::*;
#(
    parameter int LANES = BLK_LANES,
    parameter int HIST  = HIST_D
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv,
    input  sample_t [LANES-1:0]   blk,
    output sample_t [HIST-1:0]    taps
);

    typedef struct packed {
        sample_t [HIST-1:0] taps;
    } hist_st;

    hist_st st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            for (int i = 0; i < HIST; i++) begin
                st_d.taps[i] = blk[LANES-1-i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign taps = st_q.taps;

endmodule

// File: rtl/par3_fir_lane.sv
// One output lane: a full-precision sum of products over a tap window.
// win[0] is the newest sample of the window.
module par3_fir_lane
    import par3_fir_pkg::*;
#(
    parameter int TAPS = NUM_TAPS
) (
    input  sample_t [TAPS-1:0] win,
    input  coef_t   [TAPS-1:0] coef,
    output sum_t               sum
);

    sum_t acc;

    always_comb begin
        acc = '0;
        for (int t = 0; t < TAPS; t++) begin
            acc = acc + sum_t'(win[t]) * sum_t'(coef[t]);
        end
    end

    assign sum = acc;

endmodule

// File: rtl/par3_fir_oreg.sv
// Output stage: registers the lane sums on accepted blocks and delays valid.
module par3_fir_oreg
    import par3_fir_pkg::*;
#(
    parameter int LANES = BLK_LANES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vld,
    input  sum_t [LANES-1:0]   sums,
    output logic               vld_out,
    output sum_t [LANES-1:0]   data_out
);

    typedef struct packed {
        logic             vld;
        sum_t [LANES-1:0] data;
    } oreg_st;

    oreg_st st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld;
        if (vld) begin
            st_d.data = sums;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_out  = st_q.vld;
    assign data_out = st_q.data;

endmodule

// File: rtl/par3_fir.sv
// Block-parallel three-tap FIR: LANES samples in, LANES results out per clock.
// The structure requires HIST_D <= LANES.
module par3_fir
    import par3_fir_pkg::*;
#(
    parameter int    LANES  = BLK_LANES,
    parameter coef_t COEF_A = 16'sh8000,
    parameter coef_t COEF_B = 16'sh8ACF,
    parameter coef_t COEF_C = 16'sh9685
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [LANES*SAMPLE_W-1:0] in_data,
    output logic                      out_valid,
    output logic [LANES*SUM_W-1:0]    out_data
);

    localparam int TAPS = NUM_TAPS;
    localparam int HIST = HIST_D;
    // Index 0 multiplies the newest sample of each window
    localparam coef_t [TAPS-1:0] COEFS = {COEF_C, COEF_B, COEF_A};

    sample_t [LANES-1:0] blk;
    sample_t [HIST-1:0]  hist;
    sum_t    [LANES-1:0] sums;
    sum_t    [LANES-1:0] res;

    assign blk = in_data;

    par3_fir_hist #(
        .LANES (LANES),
        .HIST  (HIST)
    ) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .blk   (blk),
        .taps  (hist)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        sample_t [TAPS-1:0] win;
        for (genvar t = 0; t < TAPS; t++) begin : g_tap
            if (j >= t) begin : g_cur
                assign win[t] = blk[j-t];
            end else begin : g_old
                assign win[t] = hist[t-j-1];
            end
        end
        par3_fir_lane #(
            .TAPS (TAPS)
        ) u_lane (
            .win  (win),
            .coef (COEFS),
            .sum  (sums[j])
        );
    end

    par3_fir_oreg #(
        .LANES (LANES)
    ) u_oreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (in_valid),
        .sums     (sums),
        .vld_out  (out_valid),
        .data_out (res)
    );

    assign out_data = res;

endmodule

// File: rtl/par3_fir_chk.sv
// Property checker for the three-lane filter, attached by bind.
module par3_fir_chk
    import par3_fir_pkg::*;
#(
    parameter int    LANES  = BLK_LANES,
    parameter coef_t COEF_A = 16'sh8000,
    parameter coef_t COEF_B = 16'sh8ACF,
    parameter coef_t COEF_C = 16'sh9685
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [LANES*SAMPLE_W-1:0] in_data,
    input logic                      out_valid,
    input logic [LANES*SUM_W-1:0]    out_data
);

    sample_t [LANES-1:0] xin;
    sum_t    [LANES-1:0] yout;
    sample_t             last_new_q;
    sample_t             last_mid_q;

    assign xin  = in_data;
    assign yout = out_data;

    // Shadow of the two newest samples of the last accepted block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_new_q <= '0;
            last_mid_q <= '0;
        end else if (in_valid) begin
            last_new_q <= xin[2];
            last_mid_q <= xin[1];
        end
    end

    function automatic sum_t mac3(sample_t n0, sample_t n1, sample_t n2);
        return sum_t'(n0) * sum_t'(COEF_A) + sum_t'(n1) * sum_t'(COEF_B)
             + sum_t'(n2) * sum_t'(COEF_C);
    endfunction

    // R4
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(out_data));

    // R3
    lane_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |->
        (yout[2] == mac3($past(xin[2]), $past(xin[1]), $past(xin[0]))));

    // R2
    lane_middle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |->
        (yout[1] == mac3($past(xin[1]), $past(xin[0]), $past(last_new_q))));

    // R1
    lane_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |->
        (yout[0] == mac3($past(xin[0]), $past(last_new_q), $past(last_mid_q))));

endmodule

bind par3_fir par3_fir_chk #(
    .LANES  (LANES),
    .COEF_A (COEF_A),
    .COEF_B (COEF_B),
    .COEF_C (COEF_C)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/par3_fir_tb.sv
`timescale 1ns/1ps
module par3_fir_tb;
    import par3_fir_pkg::*;

    localparam int LANES = 3;
    localparam longint CA = -32768;
    localparam longint CB = -30001;
    localparam longint CC = -27003;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      in_valid = 1'b0;
    logic [LANES*SAMPLE_W-1:0] in_data = '0;
    logic                      out_valid;
    logic [LANES*SUM_W-1:0]    out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Scalar reference state: last two samples of the serial stream
    longint m1 = 0;
    longint m2 = 0;
    longint held [LANES];

    always #2.5 clk = ~clk;

    par3_fir u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, check at the next falling edge
    task automatic apply(input bit v, input int x0, input int x1, input int x2, input string req_tag);
        longint s [LANES];
        s[0] = longint'(x0); s[1] = longint'(x1); s[2] = longint'(x2);
        if (v) begin
            for (int i = 0; i < LANES; i++) begin
                held[i] = CA * s[i] + CB * m1 + CC * m2;
                m2 = m1;
                m1 = s[i];
            end
        end
        in_valid = v;
        in_data  = {16'(x2), 16'(x1), 16'(x0)};
        @(negedge clk);
        chk("R4", {req_tag, " out_valid"}, longint'(out_valid), longint'(v));
        for (int i = 0; i < LANES; i++) begin
            string req;
            req = v ? ((i == 0) ? "R1" : (i == 1) ? "R2" : "R3") : "R7";
            chk(req, $sformatf("%s lane%0d", req_tag, i),
                longint'($signed(out_data[i*SUM_W +: SUM_W])), held[i]);
        end
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = 48'h1234_5678_9ABC;
        repeat (3) @(negedge clk);
        // R8
        chk("R8", "out_valid in reset", longint'(out_valid), 0);
        chk("R8", "out_data in reset", longint'(out_data != '0), 0);
        rst_n = 1'b1;
        m1 = 0;
        m2 = 0;
        for (int i = 0; i < LANES; i++) held[i] = 0;
    endtask

    // R5: history is zero for the first group after reset
    task automatic test_first_block();
        apply(1'b1, 1000, -2000, 3000, "R5 first");
        apply(1'b1, 7, 8, 9, "R5 second");
        apply(1'b0, 0, 0, 0, "R5 idle");
    endtask

    // R1 R2 R3 R4: several patterns, back to back and spaced
    task automatic test_stream();
        for (int k = 0; k < 6; k++) begin
            apply(1'b1, 3*k*101 - 400, (3*k+1)*101 - 400, (3*k+2)*101 - 400, "ramp");
        end
        apply(1'b1, 12000, -12000, 12000, "alt");
        apply(1'b1, -1, 1, -1, "alt");
        apply(1'b0, 5, 5, 5, "R4 drop");
        apply(1'b1, 0, 0, 32767, "impulse");
        apply(1'b1, 0, 0, 0, "impulse tail");
        apply(1'b1, 0, 0, 0, "impulse tail");
    endtask

    // R6 R7: idle cycles with junk data leave history and output untouched
    task automatic test_gaps();
        apply(1'b1, 111, 222, 333, "R6 before gap");
        apply(1'b0, -32768, 32767, -32768, "R7 gap");
        apply(1'b0, 32767, -32768, 32767, "R7 gap");
        apply(1'b0, 999, 999, 999, "R7 gap");
        apply(1'b1, 444, 555, 666, "R6 after gap");
        apply(1'b0, 1, 2, 3, "R7 single idle");
        apply(1'b1, -444, -555, -666, "R6 after single idle");
    endtask

    // R9: full-scale values need the guard bits
    task automatic test_extremes();
        apply(1'b1, -32768, -32768, -32768, "R9 neg full");
        apply(1'b1, -32768, -32768, -32768, "R9 neg full");
        apply(1'b1, 32767, 32767, 32767, "R9 pos full");
        apply(1'b1, 32767, -32768, 32767, "R9 mixed");
        apply(1'b1, -32768, 32767, -32768, "R9 mixed");
    endtask

    initial begin
        for (int i = 0; i < LANES; i++) held[i] = 0;
        @(negedge clk);
        do_reset();
        test_first_block();
        test_stream();
        test_gaps();
        test_extremes();
        // R5 again: reset in mid-stream clears the history
        do_reset();
        test_first_block();
        apply(1'b0, 0, 0, 0, "end");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule